// File: doc/BRIEF.md
# Strap-Latched Reference Clock Selector

This block chooses the reference clock for a downstream PLL at the moment the chip is enabled. While enable is low it keeps watching a dedicated reference pin to see whether a clock is toggling there. On the first clock cycle in which enable is seen high, it captures a 3-bit strap code and the current activity verdict. If the pin is active, the pin is the reference. Otherwise the block divides the serial-link clock by a ratio that the strap code picks, and emits a one-cycle tick every N cycles as the divided reference.

The strap code also seeds a frequency code. When the divided link clock is the source, the strap code also seeds two per-channel clock-range fields. After enable, software can rewrite these three fields through a small write port. The source choice stays fixed until enable drops. Dropping enable returns every output to its reset default, and the next rising enable captures the straps again. The block runs on one clock, `clk`, which is the serial-link clock and also the sampling clock for the activity detector.

The control state machine has three states. `ST_OFF` is the state while enable is low. `ST_OFF`→`ST_LOAD` is taken when enable is seen high; in that cycle the straps and source are latched. `ST_LOAD`→`ST_ON` is taken one cycle later while enable stays high; on that edge the fields are preloaded. From `ST_LOAD` or `ST_ON` the machine returns to `ST_OFF` whenever enable is low.

Top module: `refsel_top`

## Requirements
- R1: During reset and while `en` is low, `src_sel`, `freq_code`, `range_a`, `range_b` and `div_tick` are all 0.
- R2: In the second cycle after `en` is first sampled high, `freq_code` equals the raw strap value latched at enable (0 to 7).
- R3: The reference pin is active when a completed 64-cycle window holds at least 4 rising edges (a 16-cycle pin period qualifies; a 22-cycle period or a static pin does not). From the first cycle after enable, `src_sel` is 0 (pin source) if the pin was active and 1 (divided link clock) otherwise.
- R4: With `src_sel`=1, `div_tick` pulses for exactly one cycle every N cycles. N is 39, 20, 16, 18 or 12 for strap codes 0 to 4, and 20 for codes 5, 6 and 7. The first pulse comes N cycles after the edge that latched the straps.
- R5: With `src_sel`=1, both range fields are preloaded on the second cycle to the link frequency in 5 MHz units: 93, 76, 83, 97, 92 for codes 0 to 4, and 76 for codes 5 to 7. With `src_sel`=0 they stay 0.
- R6: From the third cycle after enable, a write with `wr_en`=1 is applied on the next edge. Address 0 loads `freq_code` from `wr_data[2:0]`, address 1 loads `range_a`, address 2 loads `range_b`, and address 3 changes nothing.
- R7: Writes presented while `en` is low have no effect on any output, including after the next enable.
- R8: While `en` stays high, neither writes nor later changes of activity on the pin alter `src_sel` or the `div_tick` period.
- R9: Deasserting `en` clears all outputs on the next edge, and the next rising enable re-latches fresh strap and activity values.
- R10: With `src_sel`=0, `div_tick` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-link clock, also the sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Chip enable, synchronous to `clk` |
| strap | input | 3 | Strap code sampled at enable |
| ref_pin | input | 1 | Dedicated reference clock pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 freq, 1 range A, 2 range B |
| wr_data | input | 8 | Write data |
| src_sel | output | 1 | 0 = reference pin, 1 = divided link clock |
| freq_code | output | 3 | Reference frequency code |
| range_a | output | 8 | Channel A clock-range field |
| range_b | output | 8 | Channel B clock-range field |
| div_tick | output | 1 | One-cycle pulse of the divided reference |

## Verification
A wrong activity verdict or a wrong latched strap shows on `src_sel` one cycle after enable, and on the preloaded fields one cycle after that. A wrong divider count shows at the first `div_tick`, which arrives at most 39 cycles after enable. A state machine stuck outside `ST_ON` shows as writes that are not applied on the following cycle. State left over from a previous enable shows as nonzero outputs in the cycle after enable falls.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_ON   = 2'd2
    } sel_state_t;

    typedef enum logic [1:0] {
        REG_FREQ  = 2'd0,
        REG_RNG_A = 2'd1,
        REG_RNG_B = 2'd2,
        REG_NONE  = 2'd3
    } reg_addr_t;

    localparam int STRAP_W = 3;
    localparam int RATIO_W = 6;
    localparam int RANGE_W = 8;

    // divide ratio applied to the link clock for a strap code
    function automatic logic [RATIO_W-1:0] strap_ratio(input logic [STRAP_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0:    r = RATIO_W'(39);
            3'd1:    r = RATIO_W'(20);
            3'd2:    r = RATIO_W'(16);
            3'd3:    r = RATIO_W'(18);
            3'd4:    r = RATIO_W'(12);
            default: r = RATIO_W'(20);
        endcase
        return r;
    endfunction

    // link clock frequency in 5 MHz units for a strap code
    function automatic logic [RANGE_W-1:0] strap_range(input logic [STRAP_W-1:0] code);
        logic [RANGE_W-1:0] v;
        unique case (code)
            3'd0:    v = RANGE_W'(93);
            3'd1:    v = RANGE_W'(76);
            3'd2:    v = RANGE_W'(83);
            3'd3:    v = RANGE_W'(97);
            3'd4:    v = RANGE_W'(92);
            default: v = RANGE_W'(76);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/refsel_activity.sv
module refsel_activity #(
    parameter int WIN_LEN     = 64,
    parameter int EDGE_MIN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pin,
    output logic active
);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic [WIN_W-1:0]       win_cnt;
    logic [CNT_W-1:0]       edge_cnt;
    logic [CNT_W-1:0]       edge_total;
    logic                   win_end;

    // synchronizer chain for the asynchronous pin
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ref_pin;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ref_pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise       = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign win_end    = (win_cnt == WIN_W'(WIN_LEN - 1));
    assign edge_total = edge_cnt + CNT_W'(rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            active   <= 1'b0;
        end else if (win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            active   <= (edge_total >= CNT_W'(EDGE_MIN));
        end else begin
            win_cnt  <= win_cnt + WIN_W'(1);
            edge_cnt <= edge_total;
        end
    end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [STRAP_W-1:0] strap,
    input  logic               pin_active,
    output logic [STRAP_W-1:0] strap_q,
    output logic               src_link,
    output logic               load,
    output logic               wr_ok,
    output logic               running
);
    sel_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (en) state_nx = ST_LOAD;
            ST_LOAD: state_nx = en ? ST_ON : ST_OFF;
            ST_ON:   if (!en) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs per state
    always_comb begin
        load    = 1'b0;
        wr_ok   = 1'b0;
        running = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_LOAD: begin load = en; running = 1'b1; end
            ST_ON:   begin wr_ok = en; running = 1'b1; end
            default: ;
        endcase
    end

    // latched strap code and source choice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q  <= '0;
            src_link <= 1'b0;
        end else if (!en) begin
            strap_q  <= '0;
            src_link <= 1'b0;
        end else if (state == ST_OFF) begin
            strap_q  <= strap;
            src_link <= ~pin_active;
        end
    end
endmodule

// File: rtl/refsel_regs.sv
module refsel_regs
    import refsel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int N_CH   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  load,
    input  logic                  wr_ok,
    input  logic [STRAP_W-1:0]    strap_q,
    input  logic                  src_link,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [STRAP_W-1:0]    freq_code,
    output logic [N_CH*DATA_W-1:0] ranges
);
    logic                 wr_hit;
    logic [DATA_W-1:0]    preload;

    assign wr_hit  = wr_ok & wr_en;
    assign preload = src_link ? DATA_W'(strap_range(strap_q)) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       freq_code <= '0;
        else if (!en)                                     freq_code <= '0;
        else if (load)                                    freq_code <= strap_q;
        else if (wr_hit && wr_addr == ADDR_W'(REG_FREQ))  freq_code <= wr_data[STRAP_W-1:0];
    end

    // one range field per channel, addressed after the frequency code
    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_rng
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ch + 1);
            logic [DATA_W-1:0] rng_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             rng_q <= '0;
                else if (!en)                           rng_q <= '0;
                else if (load)                          rng_q <= preload;
                else if (wr_hit && wr_addr == MY_ADDR)  rng_q <= wr_data;
            end
            assign ranges[ch*DATA_W +: DATA_W] = rng_q;
        end
    endgenerate
endmodule

// File: rtl/refsel_div.sv
module refsel_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == ratio - DIV_W'(1));
    assign tick = run & wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (wrap)  cnt <= '0;
        else            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
#(
    parameter int WIN_LEN     = 64,
    parameter int EDGE_MIN    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [STRAP_W-1:0] strap,
    input  logic               ref_pin,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               src_sel,
    output logic [STRAP_W-1:0] freq_code,
    output logic [DATA_W-1:0]  range_a,
    output logic [DATA_W-1:0]  range_b,
    output logic               div_tick
);
    localparam int N_CH = 2;

    logic               pin_active;
    logic [STRAP_W-1:0] strap_q;
    logic               src_link;
    logic               load;
    logic               wr_ok;
    logic               running;
    logic [N_CH*DATA_W-1:0] ranges;

    refsel_activity #(
        .WIN_LEN(WIN_LEN), .EDGE_MIN(EDGE_MIN), .SYNC_STAGES(SYNC_STAGES)
    ) i_act (
        .clk(clk), .rst_n(rst_n), .ref_pin(ref_pin), .active(pin_active)
    );

    refsel_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .strap(strap),
        .pin_active(pin_active), .strap_q(strap_q), .src_link(src_link),
        .load(load), .wr_ok(wr_ok), .running(running)
    );

    refsel_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CH(N_CH)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load), .wr_ok(wr_ok),
        .strap_q(strap_q), .src_link(src_link), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .freq_code(freq_code),
        .ranges(ranges)
    );

    refsel_div #(.DIV_W(RATIO_W)) i_div (
        .clk(clk), .rst_n(rst_n), .run(running & src_link),
        .ratio(strap_ratio(strap_q)), .tick(div_tick)
    );

    assign src_sel = src_link;
    assign range_a = ranges[0 +: DATA_W];
    assign range_b = ranges[DATA_W +: DATA_W];
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [2:0] strap,
    input logic       src_sel,
    input logic [2:0] freq_code,
    input logic [7:0] range_a,
    input logic [7:0] range_b,
    input logic       div_tick
);
    // R1
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!src_sel && freq_code == 3'd0 && range_a == 8'd0 && range_b == 8'd0 && !div_tick));

    // R2
    strap_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(en, 2)) |=> (freq_code == $past(strap, 2)));

    // R8
    src_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(en, 2)) |-> $stable(src_sel));

    // R10
    tick_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> src_sel);

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick);
endmodule

bind refsel_top refsel_chk i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .strap(strap), .src_sel(src_sel),
    .freq_code(freq_code), .range_a(range_a), .range_b(range_b),
    .div_tick(div_tick)
);

// File: tb/test_refsel_top.sv
module test_refsel_top;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] strap = 3'd0;
    logic       ref_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       src_sel;
    logic [2:0] freq_code;
    logic [7:0] range_a;
    logic [7:0] range_b;
    logic       div_tick;

    int total = 0;
    int bad = 0;
    int ref_half = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    refsel_top i_refsel_top (
        .clk(clk), .rst_n(rst_n), .en(en), .strap(strap), .ref_pin(ref_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_sel(src_sel), .freq_code(freq_code), .range_a(range_a),
        .range_b(range_b), .div_tick(div_tick)
    );

    // reference pin generator: toggles every ref_half cycles, static when 0
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (ref_half == 0) begin
                ref_pin = 1'b0;
                c = 0;
            end else begin
                c++;
                if (c >= ref_half) begin
                    ref_pin = ~ref_pin;
                    c = 0;
                end
            end
        end
    end

    function automatic int exp_ratio(input logic [2:0] s);
        case (s)
            3'd0: return 39;
            3'd1: return 20;
            3'd2: return 16;
            3'd3: return 18;
            3'd4: return 12;
            default: return 20;
        endcase
    endfunction

    function automatic int exp_range(input logic [2:0] s);
        case (s)
            3'd0: return 93;
            3'd1: return 76;
            3'd2: return 83;
            3'd3: return 97;
            3'd4: return 92;
            default: return 76;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all_zero(input string req);
        chk(src_sel == 1'b0, req, src_sel, 0);
        chk(freq_code == 3'd0 && range_a == 8'd0 && range_b == 8'd0, req,
            {freq_code, range_a, range_b}, 0);
        chk(div_tick == 1'b0, req, div_tick, 0);
    endtask

    task automatic session(input logic [2:0] s, input int half, input bit act, input bit pin_flip);
        int n;
        int miss;
        int e_freq;
        int e_ra;
        int e_rb;
        int w;
        int cnt;
        int ticks;
        en = 1'b0;
        ref_half = half;
        strap = s;
        repeat (200) step();
        n = exp_ratio(s);
        en = 1'b1;
        step();                       // first cycle after latch edge
        chk(src_sel == !act, "R3 source choice", src_sel, !act);
        strap = ~s;                   // later strap changes must not matter
        step();                       // preload visible
        e_freq = s;
        e_ra = act ? 0 : exp_range(s);
        e_rb = e_ra;
        chk(freq_code == s, "R2 freq code", freq_code, e_freq);
        chk(range_a == e_ra && range_b == e_rb, "R5 range preload", range_a, e_ra);
        miss = 0;
        for (int k = 2; k <= 3 * n; k++) begin
            if (k > 2) step();
            if (div_tick != (!act && (k % n == 0))) miss++;
        end
        chk(miss == 0, act ? "R10 no tick on pin source" : "R4 tick spacing", miss, 0);
        if (pin_flip) begin
            ref_half = act ? 0 : 8;
            repeat (200) step();
            chk(src_sel == !act, "R8 pin change after enable", src_sel, !act);
        end
        for (int i = 0; i < 4; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom % 4);
            d = 8'($urandom % 256);
            wr_en = 1'b1; wr_addr = a; wr_data = d;
            step();
            wr_en = 1'b0;
            case (a)
                2'd0: e_freq = int'(d[2:0]);
                2'd1: e_ra = d;
                2'd2: e_rb = d;
                default: ;
            endcase
            chk(freq_code == e_freq[2:0] && range_a == e_ra[7:0] && range_b == e_rb[7:0],
                "R6 register write", {freq_code, range_a, range_b},
                {e_freq[2:0], e_ra[7:0], e_rb[7:0]});
        end
        chk(src_sel == !act, "R8 source after writes", src_sel, !act);
        if (!act) begin
            w = 0;
            while (!div_tick && w < 100) begin step(); w++; end
            cnt = 0;
            do begin step(); cnt++; end while (!div_tick && cnt < 100);
            chk(cnt == n, "R8 period after writes", cnt, n);
        end else begin
            ticks = 0;
            repeat (60) begin step(); if (div_tick) ticks++; end
            chk(ticks == 0, "R10 tick count", ticks, 0);
        end
        en = 1'b0;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'hAA;
        step();
        wr_en = 1'b0;
        chk_all_zero("R9 clear on disable");
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd7;
        step();
        wr_en = 1'b0;
        step();
        chk_all_zero("R7 write while low");
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk_all_zero("R1 in reset");
        rst_n = 1'b1;
        repeat (5) step();
        chk_all_zero("R1 enable low");

        // directed: boundary pin period 16 counts as active
        session(3'd0, 8, 1'b1, 1'b1);
        // directed: period 22 is too slow, link source, strap 4
        session(3'd4, 11, 1'b0, 1'b1);
        // directed: static pin, alias codes
        session(3'd7, 0, 1'b0, 1'b0);
        session(3'd5, 0, 1'b0, 1'b0);
        // R7: write while low must not survive into next enable preload
        en = 1'b0;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h55;
        step();
        wr_en = 1'b0;
        session(3'd2, 0, 1'b0, 1'b0);

        for (int i = 0; i < 16; i++) begin
            logic [2:0] s;
            bit act;
            int half;
            s = 3'($urandom % 8);
            act = 1'($urandom % 2);
            if (act) half = ($urandom % 2) ? 3 : 8;
            else     half = ($urandom % 2) ? 0 : 11;
            session(s, half, act, 1'b0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule